// File: doc/BRIEF.md
# Instruction Scheduling State Machine

This block sequences instruction execution for a small 8-bit core. It sits between the instruction decoder and the system-level sequencer. Each cycle the decoder reports what kind of instruction the instruction register holds. The scheduler then picks the next state, decides whether the fetch unit must hold, and decides whether the core may commit a result.

The block has six named states:

- **IDLE**: no execution.
- **INST**: ordinary single-cycle execution.
- **PRFX**: a prefix was seen, and the instruction that follows is being executed.
- **LDC**: the second cycle of a constant load from program memory.
- **PCWR**: a single fetch stall while a computed PC value settles.
- **HALT**: an exit state that holds a cause code.

Transitions:

- IDLE→INST on run or step.
- INST→PRFX on a prefix.
- INST/PRFX→LDC on a constant load.
- INST/PRFX→PCWR on a computed PC write.
- INST/PRFX→HALT on an invalid opcode, an overlay request, or a second prefix.
- LDC/PCWR/INST/PRFX→INST when an instruction completes and execution continues.
- LDC/PCWR/INST/PRFX→IDLE when an instruction completes and execution stops.
- HALT→HALT until reset.

The system sequencer reads the cause code and decides whether to reboot, load another overlay, or freeze. A run started by a step pulse (with run low) executes exactly one complete instruction. That instruction includes any prefix, constant-load or stall cycles. The machine then returns to IDLE.

Top module: `instr_sched`

## Requirements
- R1: While reset is asserted, and after it, the block is in IDLE (state code 0) with fetch_stall=1, wb_en=0 and status=0. It stays in IDLE while run and step are both low.
- R2: In IDLE, run=1 or step=1 moves the block to INST (code 1) at the next clock edge. The IDLE cycle itself never writes back.
- R3: In INST, an instruction with no decoder flag set gives wb_en=1 and fetch_stall=0 in that cycle. With run high and no step mode, the block stays in INST.
- R4: A constant load (dec_ldc) gives wb_en=0 in its INST/PRFX cycle. It is followed by exactly one LDC cycle (code 3) with fetch_stall=1 and wb_en=1.
- R5: A computed PC write (dec_pcwr) gives wb_en=1 and fetch_stall=0 in its INST/PRFX cycle. It is followed by exactly one PCWR cycle (code 4) with fetch_stall=1 and wb_en=0.
- R6: A prefix in INST gives wb_en=0 and always leads to PRFX (code 2), even when run and step are low. PRFX executes the next instruction like INST, including the constant-load and PC-write paths.
- R7: A prefix seen while in PRFX moves to HALT (code 5) with status=2.
- R8: An invalid opcode in INST or PRFX moves to HALT with status=1. Priority is invalid, then overlay, then prefix, then constant load, then PC write.
- R9: An overlay request moves to HALT. Status is 4 when ovl_operand equals 255, and 3 for any other operand.
- R10: HALT holds, with fetch_stall=1, wb_en=0 and an unchanged status, regardless of run, step or decoder flags, until reset. Status is 0 in every other state.
- R11: When an instruction completes (in INST, PRFX, LDC or PCWR), the block returns to IDLE if run is low or if execution began with step while run was low. It continues in INST otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Continuous execution request from the system sequencer |
| step | input | 1 | Single-instruction request pulse from the system sequencer |
| dec_prefix | input | 1 | Decoder: current instruction is a prefix |
| dec_ldc | input | 1 | Decoder: current instruction loads a constant from program memory |
| dec_pcwr | input | 1 | Decoder: current instruction writes a computed value to PC |
| dec_ovl | input | 1 | Decoder: current instruction is an overlay request |
| dec_invalid | input | 1 | Decoder: current opcode is invalid |
| ovl_operand | input | 8 | Operand value of the overlay request |
| fetch_stall | output | 1 | Hold the instruction fetch this cycle |
| wb_en | output | 1 | Allow the core to commit a result this cycle |
| status | output | 3 | Halt cause: 0 none, 1 invalid, 2 double prefix, 3 overlay, 4 halt |
| fsm_state | output | 3 | Current state code: 0 IDLE, 1 INST, 2 PRFX, 3 LDC, 4 PCWR, 5 HALT |

## Verification
The hardest situations to reach are the compound paths through PRFX:

- a prefixed constant load or PC write;
- a second prefix;
- a prefix arriving with run already low, which must still not fall back to IDLE.

Each of these needs an exact cycle-by-cycle decoder pattern, timed against the state. The stimulus therefore walks through the machine one cycle at a time. For each cycle it states both the decoder flags and the state, stall, writeback and cause expected in that cycle. Step mode is tested with run switched on in the middle of a stepped constant load, which shows that the step latch, not the live run level, ends the instruction.

// File: rtl/isched_pkg.sv
package isched_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_INST = 3'd1,
        S_PRFX = 3'd2,
        S_LDC  = 3'd3,
        S_PCWR = 3'd4,
        S_HALT = 3'd5
    } sched_state_t;

    typedef enum logic [2:0] {
        C_NONE    = 3'd0,
        C_INVALID = 3'd1,
        C_DBLPFX  = 3'd2,
        C_OVERLAY = 3'd3,
        C_HALT    = 3'd4
    } halt_cause_t;

    typedef struct packed {
        logic prefix;
        logic ldc;
        logic pcwr;
        logic ovl;
        logic invalid;
    } dec_flags_t;

endpackage

// File: rtl/isched_classify.sv
// Sorts the decoded instruction into one outcome, in fixed priority order.
module isched_classify
    import isched_pkg::*;
#(
    parameter int unsigned OPND_W    = 8,
    parameter int unsigned HALT_CODE = 255
) (
    input  logic              in_prfx,
    input  dec_flags_t        flags,
    input  logic [OPND_W-1:0] operand,
    output logic              to_halt,
    output logic              to_prfx,
    output logic              to_ldc,
    output logic              to_pcwr,
    output logic              commit_now,
    output halt_cause_t       cause
);

    localparam logic [OPND_W-1:0] HALT_OPND = OPND_W'(HALT_CODE);

    always_comb begin
        to_halt = 1'b0;
        to_prfx = 1'b0;
        to_ldc  = 1'b0;
        to_pcwr = 1'b0;
        cause   = C_NONE;
        if (flags.invalid) begin
            to_halt = 1'b1;
            cause   = C_INVALID;
        end else if (flags.ovl) begin
            to_halt = 1'b1;
            cause   = (operand == HALT_OPND) ? C_HALT : C_OVERLAY;
        end else if (flags.prefix) begin
            if (in_prfx) begin
                to_halt = 1'b1;
                cause   = C_DBLPFX;
            end else begin
                to_prfx = 1'b1;
            end
        end else if (flags.ldc) begin
            to_ldc = 1'b1;
        end else if (flags.pcwr) begin
            to_pcwr = 1'b1;
        end
    end

    // A PC write commits its value in the issue cycle; a constant load commits later.
    assign commit_now = !(to_halt || to_prfx || to_ldc);

endmodule

// File: rtl/isched_next.sv
// Next-state, cause and step-latch selection.
module isched_next
    import isched_pkg::*;
(
    input  sched_state_t state,
    input  halt_cause_t  status,
    input  logic         step_mode,
    input  logic         run,
    input  logic         step,
    input  logic         to_halt,
    input  logic         to_prfx,
    input  logic         to_ldc,
    input  logic         to_pcwr,
    input  halt_cause_t  cause,
    output sched_state_t nxt_state,
    output halt_cause_t  nxt_status,
    output logic         nxt_step_mode
);

    logic stop_after;

    assign stop_after = step_mode || !run;

    always_comb begin
        nxt_state     = state;
        nxt_status    = status;
        nxt_step_mode = step_mode;
        unique case (state)
            S_IDLE: begin
                if (run || step) begin
                    nxt_state     = S_INST;
                    nxt_step_mode = !run;
                end
            end
            S_INST, S_PRFX: begin
                if (to_halt) begin
                    nxt_state  = S_HALT;
                    nxt_status = cause;
                end else if (to_prfx) begin
                    nxt_state = S_PRFX;
                end else if (to_ldc) begin
                    nxt_state = S_LDC;
                end else if (to_pcwr) begin
                    nxt_state = S_PCWR;
                end else begin
                    nxt_state = stop_after ? S_IDLE : S_INST;
                end
            end
            S_LDC, S_PCWR: begin
                nxt_state = stop_after ? S_IDLE : S_INST;
            end
            S_HALT: begin
                nxt_state = S_HALT;
            end
            default: begin
                nxt_state  = S_IDLE;
                nxt_status = C_NONE;
            end
        endcase
    end

endmodule

// File: rtl/instr_sched.sv
module instr_sched
    import isched_pkg::*;
#(
    parameter int unsigned OPND_W    = 8,
    parameter int unsigned HALT_CODE = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    input  logic              dec_prefix,
    input  logic              dec_ldc,
    input  logic              dec_pcwr,
    input  logic              dec_ovl,
    input  logic              dec_invalid,
    input  logic [OPND_W-1:0] ovl_operand,
    output logic              fetch_stall,
    output logic              wb_en,
    output logic [2:0]        status,
    output logic [2:0]        fsm_state
);

    sched_state_t state_q, state_d;
    halt_cause_t  cause_q, cause_d, cls_cause;
    logic         step_q, step_d;
    logic         c_halt, c_prfx, c_ldc, c_pcwr, c_commit;
    dec_flags_t   flags;

    assign flags = '{prefix:  dec_prefix,
                     ldc:     dec_ldc,
                     pcwr:    dec_pcwr,
                     ovl:     dec_ovl,
                     invalid: dec_invalid};

    isched_classify #(
        .OPND_W    (OPND_W),
        .HALT_CODE (HALT_CODE)
    ) u_classify (
        .in_prfx    (state_q == S_PRFX),
        .flags      (flags),
        .operand    (ovl_operand),
        .to_halt    (c_halt),
        .to_prfx    (c_prfx),
        .to_ldc     (c_ldc),
        .to_pcwr    (c_pcwr),
        .commit_now (c_commit),
        .cause      (cls_cause)
    );

    isched_next u_next (
        .state         (state_q),
        .status        (cause_q),
        .step_mode     (step_q),
        .run           (run),
        .step          (step),
        .to_halt       (c_halt),
        .to_prfx       (c_prfx),
        .to_ldc        (c_ldc),
        .to_pcwr       (c_pcwr),
        .cause         (cls_cause),
        .nxt_state     (state_d),
        .nxt_status    (cause_d),
        .nxt_step_mode (step_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cause_q <= C_NONE;
            step_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        fetch_stall = 1'b1;
        wb_en       = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                fetch_stall = 1'b1;
                wb_en       = 1'b0;
            end
            S_INST, S_PRFX: begin
                fetch_stall = 1'b0;
                wb_en       = c_commit;
            end
            S_LDC: begin
                fetch_stall = 1'b1;
                wb_en       = 1'b1;
            end
            S_PCWR, S_HALT: begin
                fetch_stall = 1'b1;
                wb_en       = 1'b0;
            end
            default: begin
                fetch_stall = 1'b1;
                wb_en       = 1'b0;
            end
        endcase
    end

    assign status    = cause_q;
    assign fsm_state = state_q;

endmodule

// File: rtl/isched_chk.sv
module isched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_prefix,
    input logic       dec_ovl,
    input logic       dec_invalid,
    input logic       fetch_stall,
    input logic       wb_en,
    input logic [2:0] status,
    input logic [2:0] fsm_state
);

    logic exec_st;
    assign exec_st = (fsm_state == 3'd1) || (fsm_state == 3'd2);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'd0 |-> fetch_stall && !wb_en); // R1

    AST_LDC_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'd3 |-> fetch_stall && wb_en); // R4

    AST_PCWR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'd4 |=> fsm_state != 3'd4); // R5

    AST_PFX_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'd1 && dec_prefix && !dec_invalid && !dec_ovl |=> fsm_state == 3'd2); // R6

    AST_DBL_PFX: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'd2 && dec_prefix && !dec_invalid && !dec_ovl
        |=> fsm_state == 3'd5 && status == 3'd2); // R7

    AST_INVALID_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        exec_st && dec_invalid |=> fsm_state == 3'd5 && status == 3'd1); // R8

    AST_OVL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        exec_st && dec_ovl && !dec_invalid
        |=> fsm_state == 3'd5 && (status == 3'd3 || status == 3'd4)); // R9

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'd5 |=> fsm_state == 3'd5 && $stable(status)); // R10

    AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state != 3'd5 |-> status == 3'd0); // R10

endmodule

bind instr_sched isched_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_prefix  (dec_prefix),
    .dec_ovl     (dec_ovl),
    .dec_invalid (dec_invalid),
    .fetch_stall (fetch_stall),
    .wb_en       (wb_en),
    .status      (status),
    .fsm_state   (fsm_state)
);

// File: tb/test_instr_sched.sv
`timescale 1ns/1ps
module test_instr_sched;

    localparam logic [2:0] SI = 3'd0, SN = 3'd1, SP = 3'd2, SL = 3'd3, SW = 3'd4, SH = 3'd5;
    // flag vector: {prefix, ldc, pcwr, ovl, invalid}
    localparam logic [4:0] F_NONE = 5'b00000, F_PFX = 5'b10000, F_LDC = 5'b01000,
                           F_PCW  = 5'b00100, F_OVL = 5'b00010, F_INV = 5'b00001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, step = 1'b0;
    logic       dec_prefix = 1'b0, dec_ldc = 1'b0, dec_pcwr = 1'b0, dec_ovl = 1'b0, dec_invalid = 1'b0;
    logic [7:0] ovl_operand = 8'd0;
    logic       fetch_stall, wb_en;
    logic [2:0] status, fsm_state;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [2:0] st;
        logic       stall;
        logic       wb;
        logic [2:0] cause;
        string      req;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    instr_sched i_instr_sched (
        .clk(clk), .rst_n(rst_n), .run(run), .step(step),
        .dec_prefix(dec_prefix), .dec_ldc(dec_ldc), .dec_pcwr(dec_pcwr),
        .dec_ovl(dec_ovl), .dec_invalid(dec_invalid), .ovl_operand(ovl_operand),
        .fetch_stall(fetch_stall), .wb_en(wb_en), .status(status), .fsm_state(fsm_state)
    );

    task automatic compare(input exp_t e);
        total++;
        if (fsm_state !== e.st || fetch_stall !== e.stall || wb_en !== e.wb || status !== e.cause) begin
            bad++;
            $display("FAIL %s: got state=%0d stall=%0b wb=%0b status=%0d, expected state=%0d stall=%0b wb=%0b status=%0d",
                     e.req, fsm_state, fetch_stall, wb_en, status, e.st, e.stall, e.wb, e.cause);
        end
    endtask

    // Monitor: compares mid-cycle, after inputs have settled.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    // Driver: one cycle of stimulus plus the outputs expected in that same cycle.
    task automatic cyc(input logic r, input logic s, input logic [4:0] f, input logic [7:0] op,
                       input logic [2:0] est, input logic estall, input logic ewb,
                       input logic [2:0] ecause, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        run = r; step = s;
        {dec_prefix, dec_ldc, dec_pcwr, dec_ovl, dec_invalid} = f;
        ovl_operand = op;
        e.st = est; e.stall = estall; e.wb = ewb; e.cause = ecause; e.req = req;
        q.push_back(e);
    endtask

    task automatic do_reset();
        exp_t e;
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        run = 1'b0; step = 1'b0;
        {dec_prefix, dec_ldc, dec_pcwr, dec_ovl, dec_invalid} = F_NONE;
        ovl_operand = 8'd0;
        @(negedge clk);
        e.st = SI; e.stall = 1'b1; e.wb = 1'b0; e.cause = 3'd0; e.req = "R1 reset";
        compare(e);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got no end, expected run completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 idle hold, R2 start, R3 plain, R4 constant load, R5 PC write
        cyc(0,0,F_NONE,0, SI,1,0,0,"R1");
        cyc(0,0,F_NONE,0, SI,1,0,0,"R1");
        cyc(1,0,F_NONE,0, SI,1,0,0,"R2");
        cyc(1,0,F_NONE,0, SN,0,1,0,"R3");
        cyc(1,0,F_NONE,0, SN,0,1,0,"R3");
        cyc(1,0,F_LDC ,0, SN,0,0,0,"R4");
        cyc(1,0,F_NONE,0, SL,1,1,0,"R4");
        cyc(1,0,F_PCW ,0, SN,0,1,0,"R5");
        cyc(1,0,F_NONE,0, SW,1,0,0,"R5");
        // R6: prefix with run already low still enters PRFX
        cyc(0,0,F_PFX ,0, SN,0,0,0,"R6");
        cyc(0,0,F_NONE,0, SP,0,1,0,"R6");
        cyc(0,0,F_NONE,0, SI,1,0,0,"R11");
        // R11 step: plain, prefixed, constant load with run raised, PC write
        cyc(0,1,F_NONE,0, SI,1,0,0,"R2");
        cyc(0,0,F_NONE,0, SN,0,1,0,"R11");
        cyc(0,0,F_NONE,0, SI,1,0,0,"R11");
        cyc(0,1,F_NONE,0, SI,1,0,0,"R11");
        cyc(0,0,F_PFX ,0, SN,0,0,0,"R11");
        cyc(0,0,F_NONE,0, SP,0,1,0,"R11");
        cyc(0,0,F_NONE,0, SI,1,0,0,"R11");
        cyc(0,1,F_NONE,0, SI,1,0,0,"R11");
        cyc(1,0,F_LDC ,0, SN,0,0,0,"R11");
        cyc(1,0,F_NONE,0, SL,1,1,0,"R11");
        cyc(0,0,F_NONE,0, SI,1,0,0,"R11");
        cyc(0,1,F_NONE,0, SI,1,0,0,"R11");
        cyc(0,0,F_PCW ,0, SN,0,1,0,"R11");
        cyc(0,0,F_NONE,0, SW,1,0,0,"R11");
        cyc(0,0,F_NONE,0, SI,1,0,0,"R11");
        // R6 prefixed constant load and PC write, then R7 double prefix, R10 hold
        cyc(1,0,F_NONE,0, SI,1,0,0,"R2");
        cyc(1,0,F_PFX ,0, SN,0,0,0,"R6");
        cyc(1,0,F_LDC ,0, SP,0,0,0,"R6");
        cyc(1,0,F_NONE,0, SL,1,1,0,"R6");
        cyc(1,0,F_PFX ,0, SN,0,0,0,"R6");
        cyc(1,0,F_PCW ,0, SP,0,1,0,"R6");
        cyc(1,0,F_NONE,0, SW,1,0,0,"R6");
        cyc(1,0,F_PFX ,0, SN,0,0,0,"R7");
        cyc(1,0,F_PFX ,0, SP,0,0,0,"R7");
        cyc(1,0,F_NONE,0, SH,1,0,2,"R7");
        cyc(1,1,F_NONE,0, SH,1,0,2,"R10");
        cyc(0,0,F_LDC ,0, SH,1,0,2,"R10");
        do_reset();
        // R8 invalid wins over overlay
        cyc(1,0,F_NONE,0, SI,1,0,0,"R2");
        cyc(1,0,F_INV|F_OVL,8'd7, SN,0,0,0,"R8");
        cyc(1,0,F_NONE,0, SH,1,0,1,"R8");
        do_reset();
        // R9 overlay to another block
        cyc(1,0,F_NONE,0, SI,1,0,0,"R2");
        cyc(1,0,F_NONE,0, SN,0,1,0,"R3");
        cyc(1,0,F_OVL ,8'd7, SN,0,0,0,"R9");
        cyc(1,0,F_NONE,0, SH,1,0,3,"R9");
        do_reset();
        // R9 operand 255 after a prefix means halt
        cyc(1,0,F_NONE,0, SI,1,0,0,"R2");
        cyc(1,0,F_PFX ,0, SN,0,0,0,"R6");
        cyc(1,0,F_OVL ,8'd255, SP,0,0,0,"R9");
        cyc(1,0,F_NONE,0, SH,1,0,4,"R9");
        do_reset();
        // R8 invalid inside PRFX
        cyc(1,0,F_NONE,0, SI,1,0,0,"R2");
        cyc(1,0,F_PFX ,0, SN,0,0,0,"R6");
        cyc(1,0,F_INV ,0, SP,0,0,0,"R8");
        cyc(1,0,F_NONE,0, SH,1,0,1,"R8");
        do_reset();
        // R8 overlay wins over constant load; operand 254 is an ordinary overlay
        cyc(1,0,F_NONE,0, SI,1,0,0,"R2");
        cyc(1,0,F_OVL|F_LDC,8'd254, SN,0,0,0,"R8");
        cyc(1,0,F_NONE,0, SH,1,0,3,"R8");
        do_reset();
        cyc(0,0,F_NONE,0, SI,1,0,0,"R1");
        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule